// File: doc/BRIEF.md
# SMI enable and gating register

This block is a 32-bit control word on a simple I/O read/write bus. It sits at offset 0x30 above a programmable power-management base address. It holds one enable per system-management interrupt source and ANDs each enable with the matching status input. It drives a registered, active-low SMI request whenever any enabled source is pending. A rerouted NMI raises the request whether or not the TCO enable is set.

The word mixes three access types:
- A write-once enable that only the platform reset clears.
- An enable that an external lock input freezes.
- A write-only release bit. Writing 1 to it produces a one-cycle pulse that sets the global status flag, and that flag requests an SCI.

The block also watches the bus for accesses to I/O ports 0x62 and 0x66. When trapping is enabled, it claims such an access in the same cycle, so the access is not forwarded. It emits a one-cycle trap strobe, and that strobe feeds the SMI request.

Top module: `smi_ctl`

## Requirements
- R1: After reset, a read with io_rd_i high at address pm_base_i+0x30 returns 0x00000002. io_rdata_o is 0 whenever no such read is in progress.
- R2: Bits 18, 17, 14, 11 and 1 are plain read/write. Bit 1 resets to 1 and the other four reset to 0.
- R3: Writing 1 to bit 27 sets it. After that, writes of 0 leave it at 1, and a core reset does not clear it. Only plat_rst_ni clears it.
- R4: Every bit other than 27, 18, 17, 14, 13, 11 and 1 reads 0, and writes to those bits change nothing.
- R5: Bit 13 is read/write, but a write made while tco_lock_i is high leaves it unchanged.
- R6: smi_no goes low one cycle after any enabled source has its status input high, and is high otherwise. The pairings of enable bit to status input are:
  - bit 27 with sts_gpio_unl_i
  - bit 18 with sts_usb_vnd_i
  - bit 17 with sts_usb_leg_i
  - bit 14 with sts_periodic_i
  - bit 13 with sts_tco_i
  - bit 11 with the trap strobe
- R7: When nmi_reroute_i and nmi_i are both high, smi_no goes low in the next cycle even if bit 13 is 0.
- R8: Bit 7 always reads 0. A write with bit 7 set makes gbl_set_o high for exactly the next cycle. A write with bit 7 clear produces no pulse.
- R9: While bit 11 is set, each cycle with a read or a write to port 0x62 or 0x66 makes trap_o high in the next cycle, and smi_no goes low one cycle after that. While bit 11 is clear, trap_o stays low.
- R10: trap_claim_o is high during any read or write to port 0x62 or 0x66 while bit 11 is set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Core reset, async, active low |
| plat_rst_ni | input | 1 | Platform reset, async, active low; clears the write-once bit |
| pm_base_i | input | 16 | Power-management I/O base address |
| io_addr_i | input | 16 | I/O cycle address |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data, combinational |
| trap_claim_o | output | 1 | Access to a trapped port is claimed, not forwarded |
| trap_o | output | 1 | One-cycle trap strobe |
| tco_lock_i | input | 1 | Freezes the TCO enable bit |
| nmi_reroute_i | input | 1 | NMI-to-SMI rerouting enabled |
| nmi_i | input | 1 | NMI event |
| sts_gpio_unl_i | input | 1 | GPIO-unlock status |
| sts_usb_vnd_i | input | 1 | Vendor-specific USB host SMI status |
| sts_usb_leg_i | input | 1 | Legacy USB host SMI status |
| sts_periodic_i | input | 1 | Periodic status |
| sts_tco_i | input | 1 | TCO status |
| smi_no | output | 1 | SMI request, active low, registered |
| gbl_set_o | output | 1 | One-cycle global status set pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit address, register offset 0x30 and trap ports 0x62 and 0x66. Because the base address is an input, the run moves it from 0x0400 to 0x1F00 partway through. This shows that decoding follows the base while the trap ports stay fixed. A second consequence of the 16-bit width is that the bench can mix decoded, trapped and unrelated addresses, so near misses on the register address are covered. Occasional core-only and platform resets separate the two reset domains of the write-once bit.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned BIT_GPIO_UNL = 27;
  localparam int unsigned BIT_USB_VND  = 18;
  localparam int unsigned BIT_USB_LEG  = 17;
  localparam int unsigned BIT_PERIODIC = 14;
  localparam int unsigned BIT_TCO      = 13;
  localparam int unsigned BIT_TRAP     = 11;
  localparam int unsigned BIT_RELEASE  = 7;
  localparam int unsigned BIT_SPARE    = 1;

  localparam logic [REG_W-1:0] IMPL_MASK = 32'h0806_6802;
  localparam logic [REG_W-1:0] RST_VAL   = 32'h0000_0002;

  // source order inside the gating vectors
  localparam int unsigned SRC_GPIO = 0;
  localparam int unsigned SRC_UVND = 1;
  localparam int unsigned SRC_ULEG = 2;
  localparam int unsigned SRC_PER  = 3;
  localparam int unsigned SRC_TCO  = 4;
  localparam int unsigned SRC_TRAP = 5;
  localparam int unsigned NUM_SRC  = 6;

  typedef struct packed {
    logic trap;
    logic tco;
    logic periodic;
    logic usb_leg;
    logic usb_vnd;
    logic gpio_unl;
  } smi_en_t;
endpackage

// File: rtl/smi_en_regs.sv
module smi_en_regs
  import smi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             plat_rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             tco_lock_i,
  output smi_en_t          en_o,
  output logic             spare_o,
  output logic             rel_pulse_o
);
  localparam int unsigned NUM_RW = 4;
  localparam int unsigned RW_POS [NUM_RW] = '{BIT_USB_VND, BIT_USB_LEG, BIT_PERIODIC, BIT_TRAP};

  logic              once_q;
  logic [NUM_RW-1:0] rw_q;
  logic              tco_q;
  logic              spare_q;
  logic              rel_q;

  // write-once: platform reset domain only
  always_ff @(posedge clk_i or negedge plat_rst_ni) begin
    if (!plat_rst_ni)                       once_q <= 1'b0;
    else if (wr_i && wdata_i[BIT_GPIO_UNL]) once_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q    <= '0;
      tco_q   <= 1'b0;
      spare_q <= RST_VAL[BIT_SPARE];
      rel_q   <= 1'b0;
    end else begin
      if (wr_i) begin
        for (int i = 0; i < NUM_RW; i++) rw_q[i] <= wdata_i[RW_POS[i]];
        spare_q <= wdata_i[BIT_SPARE];
        if (!tco_lock_i) tco_q <= wdata_i[BIT_TCO];
      end
      rel_q <= wr_i && wdata_i[BIT_RELEASE];
    end
  end

  assign en_o.gpio_unl = once_q;
  assign en_o.usb_vnd  = rw_q[0];
  assign en_o.usb_leg  = rw_q[1];
  assign en_o.periodic = rw_q[2];
  assign en_o.trap     = rw_q[3];
  assign en_o.tco      = tco_q;
  assign spare_o       = spare_q;
  assign rel_pulse_o   = rel_q;

  // R3
  once_sticky_chk: assert property (@(posedge clk_i) disable iff (!plat_rst_ni)
    $past(once_q) |-> once_q);

  // R5
  tco_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(tco_lock_i) |-> $stable(tco_q));

  // R8
  rel_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_pulse_o |-> $past(wr_i && wdata_i[BIT_RELEASE]));
endmodule

// File: rtl/smi_io_decode.sv
module smi_io_decode #(
  parameter int unsigned              ADDR_W     = 16,
  parameter int unsigned              REG_OFS    = 'h30,
  parameter int unsigned              NUM_TRAP   = 2,
  parameter logic [NUM_TRAP*ADDR_W-1:0] TRAP_PORTS = {16'h0066, 16'h0062}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              trap_en_i,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic              claim_o,
  output logic              trap_o
);
  logic [ADDR_W-1:0]   reg_addr;
  logic                reg_hit;
  logic [NUM_TRAP-1:0] port_hit;
  logic                trap_q;

  assign reg_addr = base_i + ADDR_W'(REG_OFS);
  assign reg_hit  = (addr_i == reg_addr);
  assign reg_rd_o = rd_i && reg_hit;
  assign reg_wr_o = wr_i && reg_hit;

  for (genvar g = 0; g < NUM_TRAP; g++) begin : g_port
    assign port_hit[g] = (addr_i == TRAP_PORTS[g*ADDR_W +: ADDR_W]);
  end

  assign claim_o = trap_en_i && (rd_i || wr_i) && (|port_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= claim_o;
  end
  assign trap_o = trap_q;

  // R9
  trap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(trap_en_i && (rd_i || wr_i)));
endmodule

// File: rtl/smi_combine.sv
module smi_combine #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] sts_i,
  input  logic               nmi_route_i,
  input  logic               nmi_i,
  output logic               smi_no
);
  logic [NUM_SRC-1:0] term;
  logic               any_req;
  logic               smi_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign term[g] = en_i[g] & sts_i[g];
  end

  // rerouted NMI bypasses the TCO enable
  assign any_req = (|term) | (nmi_route_i & nmi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b1;
    else         smi_q <= ~any_req;
  end
  assign smi_no = smi_q;

  // R6
  src_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(|(en_i & sts_i)) |-> !smi_no);

  // R7
  nmi_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(nmi_route_i && nmi_i) |-> !smi_no);

  // R6
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(|(en_i & sts_i)) && !$past(nmi_route_i && nmi_i) |-> smi_no);
endmodule

// File: rtl/smi_ctl.sv
module smi_ctl
  import smi_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned REG_OFS = 'h30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              plat_rst_ni,
  input  logic [ADDR_W-1:0] pm_base_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [REG_W-1:0]  io_wdata_i,
  output logic [REG_W-1:0]  io_rdata_o,
  output logic              trap_claim_o,
  output logic              trap_o,
  input  logic              tco_lock_i,
  input  logic              nmi_reroute_i,
  input  logic              nmi_i,
  input  logic              sts_gpio_unl_i,
  input  logic              sts_usb_vnd_i,
  input  logic              sts_usb_leg_i,
  input  logic              sts_periodic_i,
  input  logic              sts_tco_i,
  output logic              smi_no,
  output logic              gbl_set_o
);
  logic               reg_rd, reg_wr;
  smi_en_t            en;
  logic               spare;
  logic [REG_W-1:0]   rd_val;
  logic [NUM_SRC-1:0] en_vec, sts_vec;
  logic               unused_wdata;

  assign unused_wdata = ^(io_wdata_i & ~IMPL_MASK & ~(REG_W'(1) << BIT_RELEASE));

  smi_io_decode #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
  ) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_i    (pm_base_i),
    .addr_i    (io_addr_i),
    .rd_i      (io_rd_i),
    .wr_i      (io_wr_i),
    .trap_en_i (en.trap),
    .reg_rd_o  (reg_rd),
    .reg_wr_o  (reg_wr),
    .claim_o   (trap_claim_o),
    .trap_o    (trap_o)
  );

  smi_en_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .plat_rst_ni (plat_rst_ni),
    .wr_i        (reg_wr),
    .wdata_i     (io_wdata_i),
    .tco_lock_i  (tco_lock_i),
    .en_o        (en),
    .spare_o     (spare),
    .rel_pulse_o (gbl_set_o)
  );

  always_comb begin
    rd_val               = '0;
    rd_val[BIT_GPIO_UNL] = en.gpio_unl;
    rd_val[BIT_USB_VND]  = en.usb_vnd;
    rd_val[BIT_USB_LEG]  = en.usb_leg;
    rd_val[BIT_PERIODIC] = en.periodic;
    rd_val[BIT_TCO]      = en.tco;
    rd_val[BIT_TRAP]     = en.trap;
    rd_val[BIT_SPARE]    = spare;
  end
  assign io_rdata_o = reg_rd ? rd_val : '0;

  always_comb begin
    en_vec            = '0;
    sts_vec           = '0;
    en_vec[SRC_GPIO]  = en.gpio_unl;  sts_vec[SRC_GPIO] = sts_gpio_unl_i;
    en_vec[SRC_UVND]  = en.usb_vnd;   sts_vec[SRC_UVND] = sts_usb_vnd_i;
    en_vec[SRC_ULEG]  = en.usb_leg;   sts_vec[SRC_ULEG] = sts_usb_leg_i;
    en_vec[SRC_PER]   = en.periodic;  sts_vec[SRC_PER]  = sts_periodic_i;
    en_vec[SRC_TCO]   = en.tco;       sts_vec[SRC_TCO]  = sts_tco_i;
    en_vec[SRC_TRAP]  = en.trap;      sts_vec[SRC_TRAP] = trap_o;
  end

  smi_combine #(.NUM_SRC(NUM_SRC)) u_comb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_vec),
    .sts_i       (sts_vec),
    .nmi_route_i (nmi_reroute_i),
    .nmi_i       (nmi_i),
    .smi_no      (smi_no)
  );

  // R4
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rdata_o & ~IMPL_MASK) == '0);

  // R1
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == '0);
endmodule

// File: tb/smi_ctl_tb.sv
module smi_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, plat_n = 1'b0;
  logic [15:0] pm_base = 16'h0400, io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic        claim, trap, smi_n, gbl;
  logic        tco_lock = 1'b0, route = 1'b0, nmi = 1'b0;
  logic        s_gpio = 1'b0, s_vnd = 1'b0, s_leg = 1'b0, s_per = 1'b0, s_tco = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smi_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .plat_rst_ni(plat_n), .pm_base_i(pm_base),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .trap_claim_o(claim), .trap_o(trap),
    .tco_lock_i(tco_lock), .nmi_reroute_i(route), .nmi_i(nmi),
    .sts_gpio_unl_i(s_gpio), .sts_usb_vnd_i(s_vnd), .sts_usb_leg_i(s_leg),
    .sts_periodic_i(s_per), .sts_tco_i(s_tco), .smi_no(smi_n), .gbl_set_o(gbl)
  );

  // reference model state
  bit m_lock, m_vnd, m_leg, m_per, m_tco, m_trapen, m_spare;
  bit m_smi_n = 1, m_gbl, m_trap;

  function automatic logic [31:0] m_val();
    logic [31:0] v = 0;
    if (m_lock)   v |= 32'h1 << 27;
    if (m_vnd)    v |= 32'h1 << 18;
    if (m_leg)    v |= 32'h1 << 17;
    if (m_per)    v |= 32'h1 << 14;
    if (m_tco)    v |= 32'h1 << 13;
    if (m_trapen) v |= 32'h1 << 11;
    if (m_spare)  v |= 32'h1 << 1;
    return v;
  endfunction

  function automatic bit is_trap_port(logic [15:0] a);
    return a == 16'h0062 || a == 16'h0066;
  endfunction

  always @(posedge clk) begin
    bit wr_hit, req, n_trap, n_gbl;
    wr_hit = io_wr && (io_addr == 16'(pm_base + 16'h30));
    req = (m_lock && s_gpio) || (m_vnd && s_vnd) || (m_leg && s_leg) ||
          (m_per && s_per) || (m_tco && s_tco) || m_trap || (route && nmi);
    n_trap = m_trapen && (io_rd || io_wr) && is_trap_port(io_addr);
    n_gbl = wr_hit && io_wdata[7];
    if (!plat_n) m_lock = 0;
    else if (wr_hit && io_wdata[27]) m_lock = 1;
    if (!rst_n) begin
      m_vnd = 0; m_leg = 0; m_per = 0; m_tco = 0; m_trapen = 0; m_spare = 1;
      m_smi_n = 1; m_gbl = 0; m_trap = 0;
    end else begin
      m_smi_n = !req; m_gbl = n_gbl; m_trap = n_trap;
      if (wr_hit) begin
        m_vnd = io_wdata[18]; m_leg = io_wdata[17]; m_per = io_wdata[14];
        m_trapen = io_wdata[11]; m_spare = io_wdata[1];
        if (!tco_lock) m_tco = io_wdata[13];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [31:0] e_rd;
    @(negedge clk);
    e_rd = (io_rd && io_addr == 16'(pm_base + 16'h30)) ? m_val() : 32'h0;
    chk("R1", io_rdata, e_rd);
    chk("R6", 32'(smi_n), 32'(m_smi_n));
    chk("R8", 32'(gbl), 32'(m_gbl));
    chk("R9", 32'(trap), 32'(m_trap));
    chk("R10", 32'(claim), 32'(m_trapen && (io_rd || io_wr) && is_trap_port(io_addr)));
  endtask

  task automatic do_wr(logic [15:0] a, logic [31:0] d);
    io_wr = 1; io_addr = a; io_wdata = d;
    tick();
    io_wr = 0;
  endtask

  task automatic do_rd(logic [15:0] a, output logic [31:0] d);
    io_rd = 1; io_addr = a;
    tick();
    d = io_rdata;
    io_rd = 0;
  endtask

  initial begin
    logic [31:0] rv;
    logic [15:0] ra;
    int hold;
    ra = pm_base + 16'h30;
    repeat (3) tick();
    rst_n = 1; plat_n = 1;
    tick();
    // R1 reset value
    do_rd(ra, rv); chk("R1", rv, 32'h2);
    // R2 R4 all ones; R8 release pulse
    do_wr(ra, 32'hFFFF_FFFF); chk("R8", 32'(gbl), 1);
    do_rd(ra, rv); chk("R8", 32'(gbl), 0); chk("R4", rv, 32'h0806_6802);
    // R3 write-once holds against zero write; R8 no pulse for zero
    do_wr(ra, 32'h0); chk("R8", 32'(gbl), 0);
    do_rd(ra, rv); chk("R3", rv, 32'h0800_0000);
    // R5 lock freezes bit 13
    tco_lock = 1; do_wr(ra, 32'h2000);
    do_rd(ra, rv); chk("R5", rv, 32'h0800_0000);
    tco_lock = 0; do_wr(ra, 32'h2002);
    tco_lock = 1; do_wr(ra, 32'h0);
    do_rd(ra, rv); chk("R5", rv, 32'h0800_2000);
    tco_lock = 0;
    // R3 core reset keeps bit 27
    rst_n = 0; tick(); rst_n = 1; tick();
    do_rd(ra, rv); chk("R3", rv, 32'h0800_0002);
    // R3 platform reset clears it
    rst_n = 0; plat_n = 0; tick(); rst_n = 1; plat_n = 1; tick();
    do_rd(ra, rv); chk("R3", rv, 32'h2);
    // R7 nmi bypass with TCO enable clear
    route = 1; nmi = 1; tick(); chk("R7", 32'(smi_n), 0);
    nmi = 0; tick(); chk("R7", 32'(smi_n), 1);
    // R6 enabled legacy USB source
    do_wr(ra, 32'h0002_0000);
    s_leg = 1; tick(); chk("R6", 32'(smi_n), 0);
    s_leg = 0; s_vnd = 1; tick(); chk("R6", 32'(smi_n), 1);
    s_vnd = 0;
    // R10 R9 trap disabled then enabled
    io_rd = 1; io_addr = 16'h0066; tick(); chk("R10", 32'(claim), 0); chk("R9", 32'(trap), 0);
    io_rd = 0;
    do_wr(ra, 32'h0000_0800);
    io_rd = 1; io_addr = 16'h0062; tick();
    chk("R10", 32'(claim), 1); chk("R9", 32'(trap), 1); chk("R9", 32'(smi_n), 1);
    io_rd = 0; tick(); chk("R9", 32'(trap), 0); chk("R9", 32'(smi_n), 0);
    tick(); chk("R9", 32'(smi_n), 1);
    do_rd(16'h0063, rv); chk("R1", rv, 0);
    // random phase against the model
    hold = 0;
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i == 2000) pm_base = 16'h1F00;
      if (hold > 0) begin
        hold--;
        if (hold == 0) begin rst_n = 1; plat_n = 1; end
      end else if ($urandom_range(0, 299) == 0) begin
        rst_n = 0; hold = 2;
        if ($urandom_range(0, 1) == 0) plat_n = 0;
      end
      r = $urandom_range(0, 99);
      if (r < 40)      io_addr = pm_base + 16'h30;
      else if (r < 60) io_addr = 16'h0062;
      else if (r < 75) io_addr = 16'h0066;
      else if (r < 85) io_addr = pm_base + 16'h34;
      else             io_addr = 16'($urandom);
      io_wr = (hold == 0) && ($urandom_range(0, 3) == 0);
      io_rd = ($urandom_range(0, 2) == 0);
      io_wdata = $urandom;
      io_wdata[27] = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 19) == 0) tco_lock = ~tco_lock;
      route = ($urandom_range(0, 1) == 0);
      nmi = ($urandom_range(0, 15) == 0);
      s_gpio = ($urandom_range(0, 3) == 0);
      s_vnd = ($urandom_range(0, 3) == 0);
      s_leg = ($urandom_range(0, 3) == 0);
      s_per = ($urandom_range(0, 3) == 0);
      s_tco = ($urandom_range(0, 3) == 0);
      tick();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule